// File: doc/BRIEF.md
# Shifted-Operand Generator with Carry-Out

This block forms the second source operand of a 32-bit integer data-processing path, together with the carry that the shift produces. It is purely combinational. The operand can be shifted left, shifted right logically or arithmetically, rotated right, or rotated right by one bit through the incoming carry. The shift count comes from a 5-bit field, from the low byte of a count register, or the operand is built as an 8-bit constant rotated by an even amount. Decoding instruction words into these controls happens elsewhere.

The carry result is only reported when the caller asks for flags to be updated, and even then only for shift cases that really produce a carry. When no carry is produced, `carry_valid_o` stays low and `carry_o` repeats `carry_i`, so a flag register downstream can simply load `carry_o` or hold its value. There is no stream data here and no handshake: every output follows the inputs within the same cycle.

Top module: `sop_shifter_unit`

## Requirements
- R1: Encodings are fixed: `shift_kind_i` 0 = left logical, 1 = right logical, 2 = right arithmetic, 3 = rotate right; `amt_src_i` 00 = count from `imm_amt_i`, 01 = count from `shamt_reg_i`, 1x = rotated constant. A left shift with a field count of 0 passes the operand through, `carry_valid_o` low.
- R2: A field count of 0 with a right logical or right arithmetic kind acts as a count of 32.
- R3: A field count of 0 with the rotate kind gives `{carry_i, operand_i[31:1]}` and a new carry of `operand_i[0]`.
- R4: A register count of 0 passes the operand through with `carry_valid_o` low and `carry_o` equal to `carry_i`; counts up to 255 are honoured.
- R5: Left shift by n in 1..31 yields `operand_i << n` with carry `operand_i[32-n]`; by 32 yields 0 with carry `operand_i[0]`; by more than 32 yields 0 with carry 0.
- R6: Right logical shift by n in 1..31 yields `operand_i >> n` with carry `operand_i[n-1]`; by 32 yields 0 with carry `operand_i[31]`; by more than 32 yields 0 with carry 0.
- R7: Right arithmetic shift by n in 1..31 sign-fills with carry `operand_i[n-1]`; by 32 or more every bit and the carry equal `operand_i[31]`.
- R8: Rotate by a nonzero count rotates right by the count modulo 32, and the carry is bit 31 of the rotated value (including counts that are multiples of 32).
- R9: In rotated-constant mode the result is `operand_i[7:0]` zero-extended and rotated right by twice `imm_amt_i[3:0]`; `imm_amt_i[4]` and `operand_i[31:8]` are ignored. With a nonzero rotation the carry is bit 31 of the result; with zero rotation no carry is produced.
- R10: With `flags_en_i` low, `carry_valid_o` is low and the result is unaffected.
- R11: Whenever `carry_valid_o` is low, `carry_o` equals `carry_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Value to be shifted, or the constant byte in rotated-constant mode |
| shift_kind_i | input | 2 | Shift kind (see R1) |
| amt_src_i | input | 2 | Source of the count (see R1) |
| imm_amt_i | input | 5 | Field count, or rotation field in rotated-constant mode |
| shamt_reg_i | input | 8 | Low byte of the count register |
| carry_i | input | 1 | Current carry flag |
| flags_en_i | input | 1 | Caller will update flags |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | New carry, or `carry_i` when none is produced |
| carry_valid_o | output | 1 | High when `carry_o` carries a freshly produced carry |

## Verification
Each shift kind is applied with field counts and register counts swept across 1..31 and past 32 against a bit-level model, which separates off-by-one carry selection from wrong fill at the top of the word. Dedicated vectors at counts 0, 32, 33 and 255 tell the zero-count reinterpretations and the out-of-range rules apart, because those produce distinct results and carries on operands with differing end bits. The rotated constant is tried with zero, small and large rotations and with junk above the byte, and flag-disabled vectors confirm the carry is held.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

endpackage

// File: rtl/sop_amount_dec.sv
module sop_amount_dec
  import sop_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  localparam int LOG = $clog2(WIDTH)
) (
  input  shift_kind_e      kind_i,
  input  logic [1:0]       src_i,
  input  logic [LOG-1:0]   imm_amt_i,
  input  logic [AMT_W-1:0] reg_amt_i,
  output logic [AMT_W-1:0] eff_amt_o,
  output logic             rrx_o,
  output logic             rotimm_o,
  output logic [LOG-1:0]   rot_amt_o
);

  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(WIDTH);

  always_comb begin
    eff_amt_o = '0;
    rrx_o     = 1'b0;
    rotimm_o  = 1'b0;
    rot_amt_o = '0;
    if (src_i[1]) begin
      // constant byte rotated by an even amount
      rotimm_o  = 1'b1;
      rot_amt_o = {imm_amt_i[LOG-2:0], 1'b0};
    end else if (src_i[0]) begin
      eff_amt_o = reg_amt_i;
    end else if (imm_amt_i != '0) begin
      eff_amt_o = {{(AMT_W-LOG){1'b0}}, imm_amt_i};
    end else begin
      // zero field count is reinterpreted per kind
      unique case (kind_i)
        SK_LSR, SK_ASR: eff_amt_o = FULL_AMT;
        SK_ROR:         rrx_o     = 1'b1;
        default:        eff_amt_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/sop_rotator.sv
module sop_rotator #(
  parameter int WIDTH = 32,
  localparam int LOG = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [LOG-1:0]   amt_i,
  output logic [WIDTH-1:0] data_o
);

  logic [WIDTH-1:0] stage [LOG+1];

  assign stage[0] = data_i;

  for (genvar s = 0; s < LOG; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = amt_i[s] ? {stage[s][SH-1:0], stage[s][WIDTH-1:SH]}
                                 : stage[s];
  end

  assign data_o = stage[LOG];

endmodule

// File: rtl/sop_shift_core.sv
module sop_shift_core
  import sop_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  localparam int LOG = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand_i,
  input  shift_kind_e      kind_i,
  input  logic [AMT_W-1:0] eff_amt_i,
  input  logic             rrx_i,
  input  logic             rotimm_i,
  input  logic             rot_nz_i,
  input  logic [WIDTH-1:0] rot_val_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_new_o,
  output logic             carry_gen_o
);

  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(WIDTH);

  logic [LOG-1:0] amt_lo;
  logic           amt_zero, amt_full, amt_over;
  logic [WIDTH:0] lsl_ext, lsr_ext, asr_ext;

  assign amt_lo   = eff_amt_i[LOG-1:0];
  assign amt_zero = (eff_amt_i == '0);
  assign amt_full = (eff_amt_i == FULL_AMT);
  assign amt_over = (eff_amt_i > FULL_AMT);

  // one extra bit on the exit side catches the last bit shifted out
  assign lsl_ext = {1'b0, operand_i} << amt_lo;
  assign lsr_ext = {operand_i, 1'b0} >> amt_lo;
  assign asr_ext = $unsigned($signed({operand_i, 1'b0}) >>> amt_lo);

  always_comb begin
    result_o    = operand_i;
    carry_new_o = carry_i;
    carry_gen_o = 1'b0;
    if (rotimm_i) begin
      result_o    = rot_val_i;
      carry_new_o = rot_val_i[WIDTH-1];
      carry_gen_o = rot_nz_i;
    end else if (rrx_i) begin
      result_o    = {carry_i, operand_i[WIDTH-1:1]};
      carry_new_o = operand_i[0];
      carry_gen_o = 1'b1;
    end else if (!amt_zero) begin
      carry_gen_o = 1'b1;
      unique case (kind_i)
        SK_LSL: begin
          if (amt_over) begin
            result_o = '0; carry_new_o = 1'b0;
          end else if (amt_full) begin
            result_o = '0; carry_new_o = operand_i[0];
          end else begin
            result_o = lsl_ext[WIDTH-1:0]; carry_new_o = lsl_ext[WIDTH];
          end
        end
        SK_LSR: begin
          if (amt_over) begin
            result_o = '0; carry_new_o = 1'b0;
          end else if (amt_full) begin
            result_o = '0; carry_new_o = operand_i[WIDTH-1];
          end else begin
            result_o = lsr_ext[WIDTH:1]; carry_new_o = lsr_ext[0];
          end
        end
        SK_ASR: begin
          if (amt_over || amt_full) begin
            result_o    = {WIDTH{operand_i[WIDTH-1]}};
            carry_new_o = operand_i[WIDTH-1];
          end else begin
            result_o = asr_ext[WIDTH:1]; carry_new_o = asr_ext[0];
          end
        end
        default: begin
          result_o    = rot_val_i;
          carry_new_o = rot_val_i[WIDTH-1];
        end
      endcase
    end
  end

endmodule

// File: rtl/sop_shifter_unit.sv
module sop_shifter_unit
  import sop_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  localparam int LOG = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [1:0]       shift_kind_i,
  input  logic [1:0]       amt_src_i,
  input  logic [LOG-1:0]   imm_amt_i,
  input  logic [AMT_W-1:0] shamt_reg_i,
  input  logic             carry_i,
  input  logic             flags_en_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             carry_valid_o
);

  shift_kind_e      kind;
  logic [AMT_W-1:0] eff_amt;
  logic             rrx, rotimm;
  logic [LOG-1:0]   rot_amt, rotor_amt;
  logic [WIDTH-1:0] rotor_in, rotor_out, core_res;
  logic             c_new, c_gen;

  assign kind = shift_kind_e'(shift_kind_i);

  sop_amount_dec #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dec (
    .kind_i    (kind),
    .src_i     (amt_src_i),
    .imm_amt_i (imm_amt_i),
    .reg_amt_i (shamt_reg_i),
    .eff_amt_o (eff_amt),
    .rrx_o     (rrx),
    .rotimm_o  (rotimm),
    .rot_amt_o (rot_amt)
  );

  // one rotator serves both register/field rotates and the rotated constant
  assign rotor_in  = rotimm ? {{(WIDTH-8){1'b0}}, operand_i[7:0]} : operand_i;
  assign rotor_amt = rotimm ? rot_amt : eff_amt[LOG-1:0];

  sop_rotator #(.WIDTH(WIDTH)) u_rot (
    .data_i (rotor_in),
    .amt_i  (rotor_amt),
    .data_o (rotor_out)
  );

  sop_shift_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_core (
    .operand_i   (operand_i),
    .kind_i      (kind),
    .eff_amt_i   (eff_amt),
    .rrx_i       (rrx),
    .rotimm_i    (rotimm),
    .rot_nz_i    (rot_amt != '0),
    .rot_val_i   (rotor_out),
    .carry_i     (carry_i),
    .result_o    (core_res),
    .carry_new_o (c_new),
    .carry_gen_o (c_gen)
  );

  assign result_o      = core_res;
  assign carry_valid_o = flags_en_i & c_gen;
  assign carry_o       = carry_valid_o ? c_new : carry_i;

endmodule

// File: rtl/sop_shifter_unit_chk.sv
module sop_shifter_unit_chk #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  localparam int LOG = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] operand_i,
  input logic [1:0]       shift_kind_i,
  input logic [1:0]       amt_src_i,
  input logic [LOG-1:0]   imm_amt_i,
  input logic [AMT_W-1:0] shamt_reg_i,
  input logic             carry_i,
  input logic             flags_en_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             carry_valid_o
);

  always_comb begin
    // R10
    if (!flags_en_i) flags_off_chk: assert (!carry_valid_o);
    // R11
    if (!carry_valid_o) carry_hold_chk: assert (carry_o == carry_i);
    // R4
    if (amt_src_i == 2'b01 && shamt_reg_i == '0)
      zero_reg_pass_chk: assert (result_o == operand_i && !carry_valid_o);
    // R3
    if (amt_src_i == 2'b00 && shift_kind_i == 2'd3 && imm_amt_i == '0)
      rrx_chk: assert (result_o == {carry_i, operand_i[WIDTH-1:1]} &&
                       (!flags_en_i || carry_o == operand_i[0]));
    // R7
    if (amt_src_i[1] == 1'b0 && shift_kind_i == 2'd2)
      asr_sign_chk: assert (result_o[WIDTH-1] == operand_i[WIDTH-1]);
    // R8
    if (amt_src_i == 2'b01 && shift_kind_i == 2'd3 && shamt_reg_i != '0 && flags_en_i)
      ror_carry_chk: assert (carry_valid_o && carry_o == result_o[WIDTH-1]);
    // R9
    if (amt_src_i[1])
      rotimm_bits_chk: assert ($countones(result_o) == $countones(operand_i[7:0]));
  end

endmodule

bind sop_shifter_unit sop_shifter_unit_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
  .operand_i     (operand_i),
  .shift_kind_i  (shift_kind_i),
  .amt_src_i     (amt_src_i),
  .imm_amt_i     (imm_amt_i),
  .shamt_reg_i   (shamt_reg_i),
  .carry_i       (carry_i),
  .flags_en_i    (flags_en_i),
  .result_o      (result_o),
  .carry_o       (carry_o),
  .carry_valid_o (carry_valid_o)
);

// File: tb/sop_shifter_unit_test.sv
`timescale 1ns/1ps
module sop_shifter_unit_test;

  logic        clk = 1'b0;
  logic [31:0] operand;
  logic [1:0]  kind, src;
  logic [4:0]  imm_amt;
  logic [7:0]  shreg;
  logic        cin, fen;
  logic [31:0] res;
  logic        cout, cval;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;

  sop_shifter_unit uut (
    .operand_i     (operand),
    .shift_kind_i  (kind),
    .amt_src_i     (src),
    .imm_amt_i     (imm_amt),
    .shamt_reg_i   (shreg),
    .carry_i       (cin),
    .flags_en_i    (fen),
    .result_o      (res),
    .carry_o       (cout),
    .carry_valid_o (cval)
  );

  task automatic drive(input logic [31:0] op, input logic [1:0] k, input logic [1:0] s,
                       input logic [4:0] ia, input logic [7:0] ra,
                       input logic ci, input logic fe);
    @(negedge clk);
    operand = op; kind = k; src = s; imm_amt = ia; shreg = ra; cin = ci; fen = fe;
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic ec, input logic ev);
    n_vec++;
    if (res !== er || cout !== ec || cval !== ev) begin
      n_bad++;
      $display("FAIL %s: got res=%h c=%b v=%b, expected res=%h c=%b v=%b",
               tag, res, cout, cval, er, ec, ev);
    end
  endtask

  // bit-level model of a shift by n >= 1
  task automatic model(input logic [31:0] op, input logic [1:0] k, input int n,
                       output logic [31:0] r, output logic c);
    for (int i = 0; i < 32; i++) begin
      case (k)
        2'd0: r[i] = (i - n >= 0) ? op[i-n] : 1'b0;
        2'd1: r[i] = (i + n < 32) ? op[i+n] : 1'b0;
        2'd2: r[i] = (i + n < 32) ? op[i+n] : op[31];
        default: r[i] = op[(i + n) % 32];
      endcase
    end
    case (k)
      2'd0: c = (n <= 32) ? op[32-n] : 1'b0;
      2'd1: c = (n <= 32) ? op[n-1] : 1'b0;
      2'd2: c = (n <= 32) ? op[n-1] : op[31];
      default: c = r[31];
    endcase
  endtask

  task automatic t_idle();
    drive(32'h0, 2'd0, 2'b00, 5'd0, 8'd0, 1'b0, 1'b0);
    check("R1 idle inputs", 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_lsl_zero();
    drive(32'hDEADBEEF, 2'd0, 2'b00, 5'd0, 8'd0, 1'b1, 1'b1);
    check("R1 lsl field 0", 32'hDEADBEEF, 1'b1, 1'b0);
  endtask

  task automatic t_imm_zero_right();
    drive(32'h80000001, 2'd1, 2'b00, 5'd0, 8'd0, 1'b0, 1'b1);
    check("R2 lsr field 0", 32'h0, 1'b1, 1'b1);
    drive(32'h80000000, 2'd2, 2'b00, 5'd0, 8'd0, 1'b0, 1'b1);
    check("R2 asr field 0 neg", 32'hFFFFFFFF, 1'b1, 1'b1);
    drive(32'h7FFFFFFF, 2'd2, 2'b00, 5'd0, 8'd0, 1'b1, 1'b1);
    check("R2 asr field 0 pos", 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_rrx();
    drive(32'h00000003, 2'd3, 2'b00, 5'd0, 8'd0, 1'b1, 1'b1);
    check("R3 rrx cin1", 32'h80000001, 1'b1, 1'b1);
    drive(32'h80000002, 2'd3, 2'b00, 5'd0, 8'd0, 1'b0, 1'b1);
    check("R3 rrx cin0", 32'h40000001, 1'b0, 1'b1);
  endtask

  task automatic t_reg_amt();
    drive(32'h12345678, 2'd0, 2'b01, 5'd7, 8'd0, 1'b1, 1'b1);
    check("R4 reg count 0", 32'h12345678, 1'b1, 1'b0);
    drive(32'h12345678, 2'd0, 2'b01, 5'd0, 8'd4, 1'b0, 1'b1);
    check("R4 reg count 4", 32'h23456780, 1'b1, 1'b1);
    drive(32'h80000000, 2'd2, 2'b01, 5'd0, 8'd255, 1'b0, 1'b1);
    check("R4 reg count 255", 32'hFFFFFFFF, 1'b1, 1'b1);
  endtask

  task automatic t_lsl();
    drive(32'h00000001, 2'd0, 2'b01, 5'd0, 8'd32, 1'b0, 1'b1);
    check("R5 lsl 32", 32'h0, 1'b1, 1'b1);
    drive(32'hFFFFFFFF, 2'd0, 2'b01, 5'd0, 8'd33, 1'b1, 1'b1);
    check("R5 lsl 33", 32'h0, 1'b0, 1'b1);
    drive(32'h80000000, 2'd0, 2'b00, 5'd1, 8'd0, 1'b0, 1'b1);
    check("R5 lsl 1", 32'h0, 1'b1, 1'b1);
    drive(32'h00000003, 2'd0, 2'b00, 5'd31, 8'd0, 1'b0, 1'b1);
    check("R5 lsl 31", 32'h80000000, 1'b1, 1'b1);
  endtask

  task automatic t_lsr();
    drive(32'h80000000, 2'd1, 2'b01, 5'd0, 8'd32, 1'b0, 1'b1);
    check("R6 lsr 32", 32'h0, 1'b1, 1'b1);
    drive(32'hFFFFFFFF, 2'd1, 2'b01, 5'd0, 8'd200, 1'b1, 1'b1);
    check("R6 lsr 200", 32'h0, 1'b0, 1'b1);
    drive(32'h0000001F, 2'd1, 2'b00, 5'd4, 8'd0, 1'b0, 1'b1);
    check("R6 lsr 4", 32'h00000001, 1'b1, 1'b1);
    drive(32'h40000000, 2'd1, 2'b00, 5'd31, 8'd0, 1'b0, 1'b1);
    check("R6 lsr 31", 32'h0, 1'b1, 1'b1);
  endtask

  task automatic t_asr();
    drive(32'h40000000, 2'd2, 2'b01, 5'd0, 8'd40, 1'b1, 1'b1);
    check("R7 asr 40 pos", 32'h0, 1'b0, 1'b1);
    drive(32'hF0000008, 2'd2, 2'b00, 5'd4, 8'd0, 1'b0, 1'b1);
    check("R7 asr 4", 32'hFF000000, 1'b1, 1'b1);
    drive(32'h80000001, 2'd2, 2'b00, 5'd1, 8'd0, 1'b0, 1'b1);
    check("R7 asr 1", 32'hC0000000, 1'b1, 1'b1);
  endtask

  task automatic t_ror();
    drive(32'h000000A5, 2'd3, 2'b00, 5'd8, 8'd0, 1'b0, 1'b1);
    check("R8 ror field 8", 32'hA5000000, 1'b1, 1'b1);
    drive(32'h80000000, 2'd3, 2'b01, 5'd0, 8'd32, 1'b0, 1'b1);
    check("R8 ror reg 32", 32'h80000000, 1'b1, 1'b1);
    drive(32'h0000000F, 2'd3, 2'b01, 5'd0, 8'd36, 1'b0, 1'b1);
    check("R8 ror reg 36", 32'hF0000000, 1'b1, 1'b1);
    drive(32'h00000002, 2'd3, 2'b00, 5'd1, 8'd0, 1'b1, 1'b1);
    check("R8 ror field 1", 32'h00000001, 1'b0, 1'b1);
  endtask

  task automatic t_rotimm();
    drive(32'h000000FF, 2'd0, 2'b10, 5'd4, 8'd0, 1'b0, 1'b1);
    check("R9 rot 8", 32'hFF000000, 1'b1, 1'b1);
    drive(32'h000000FF, 2'd2, 2'b11, 5'd1, 8'd0, 1'b0, 1'b1);
    check("R9 rot 2", 32'hC000003F, 1'b1, 1'b1);
    drive(32'h00000080, 2'd0, 2'b10, 5'd0, 8'd0, 1'b1, 1'b1);
    check("R9 rot 0", 32'h00000080, 1'b1, 1'b0);
    drive(32'hFFFFFF01, 2'd0, 2'b10, 5'd0, 8'd0, 1'b0, 1'b1);
    check("R9 upper bits ignored", 32'h00000001, 1'b0, 1'b0);
    drive(32'h0000007F, 2'd0, 2'b10, 5'd8, 8'd0, 1'b1, 1'b1);
    check("R9 rot 16", 32'h007F0000, 1'b0, 1'b1);
    drive(32'h000000FF, 2'd0, 2'b10, 5'h11, 8'd0, 1'b0, 1'b1);
    check("R9 field bit4 ignored", 32'hC000003F, 1'b1, 1'b1);
  endtask

  task automatic t_no_flags();
    drive(32'h80000000, 2'd1, 2'b00, 5'd0, 8'd0, 1'b0, 1'b0);
    check("R10 lsr32 no flags", 32'h0, 1'b0, 1'b0);
    drive(32'h00000001, 2'd3, 2'b00, 5'd0, 8'd0, 1'b1, 1'b0);
    check("R11 rrx no flags", 32'h80000000, 1'b1, 1'b0);
    drive(32'h000000FF, 2'd0, 2'b10, 5'd4, 8'd0, 1'b0, 1'b0);
    check("R10 rot const no flags", 32'hFF000000, 1'b0, 1'b0);
  endtask

  task automatic t_sweep();
    logic [31:0] ops [3];
    logic [31:0] er;
    logic        ec;
    ops[0] = 32'h9E3779B9;
    ops[1] = 32'h6A09E667;
    ops[2] = 32'hF000000F;
    for (int o = 0; o < 3; o++) begin
      for (int k = 0; k < 4; k++) begin
        for (int n = 1; n < 32; n++) begin
          model(ops[o], 2'(k), n, er, ec);
          drive(ops[o], 2'(k), 2'b00, 5'(n), 8'd0, 1'b0, 1'b1);
          check("R5/R6/R7/R8 field sweep", er, ec, 1'b1);
        end
        for (int n = 1; n < 72; n++) begin
          model(ops[o], 2'(k), n, er, ec);
          drive(ops[o], 2'(k), 2'b01, 5'd0, 8'(n), 1'b1, 1'b1);
          check("R4 reg sweep", er, ec, 1'b1);
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    operand = '0; kind = '0; src = '0; imm_amt = '0; shreg = '0; cin = 1'b0; fen = 1'b0;
    t_idle();
    t_lsl_zero();
    t_imm_zero_right();
    t_rrx();
    t_reg_amt();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_rotimm();
    t_no_flags();
    t_sweep();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule